// File: doc/BRIEF.md
# Calendar Time Counter with Deferred Write Commit

This block keeps wall-clock time (seconds, minutes, hours) and the calendar date (day, month, year offset, leap-year flag) in two packed 32-bit registers. The counters advance once per second on a tick qualified by the slow timekeeping clock enable. The date rolls over at month and year ends, using month lengths that depend on a leap-year bit supplied by software rather than computed.

Software writes go into a shadow copy and reach the live counters only after a request has crossed a synchronizer that is clocked by the slow enable. While a write is in flight, a busy flag in the control word reads as 1, and the live register keeps counting and reading its old value. On the slow edge where a write lands, the second tick is dropped, so that the committed value is the one that appears and is not the value plus one. Software polls the busy flags and waits for them to clear before it writes the same register again. A write to a register whose flag is still set is dropped.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the time word reads 00:00:00, the date word reads day 1, month 1, year offset 0, leap flag 0, and the control word reads 0.
- R2: Selector 1 reads the time word: seconds in bits [5:0], minutes in [13:8], hours in [20:16]. Selector 2 reads the date word: day in [4:0], month in [11:8], year offset from 1970 in [21:16], leap flag in bit 22. Selector 0 reads the control word and selector 3 reads zero. All other bits read zero, and written values keep only the field bits.
- R3: An accepted write to the time word sets control bit 8, and an accepted write to the date word sets control bit 7, both visible from the cycle after the write. Control bit 9 and all other control bits read 0.
- R4: A busy flag stays set until its write commits. The commit happens on the (SYNC_STAGES+1)-th cycle with slow_en high that comes strictly after the write cycle, which is the third such cycle with the default setting. From the next cycle the flag reads 0 and the register reads the written value.
- R5: A write to a register whose busy flag is set is ignored, and any write to the control word or to selector 3 has no effect.
- R6: Until a write commits, the register it targets keeps returning its live, still-advancing value.
- R7: On a cycle with slow_en and sec_tick both high, seconds advance. Seconds roll from 59 to 0 and carry to minutes, minutes roll from 59 to 0 and carry to hours, and hours roll from 23 to 0 and carry to the day.
- R8: The last day of a month is 30 for months 4, 6, 9 and 11, 28 for month 2 (29 when the leap flag is 1), and 31 otherwise. Past the last day, the day goes back to 1 and the month increments.
- R9: Month 12 rolls to 1 and increments the year offset. The year offset wraps from 63 to 0. The leap flag is never changed by counting.
- R10: On a slow edge where either register commits, the second tick is suppressed for both registers.
- R11: A field at or above its last value wraps as if it were at its last value, so an out-of-range second, minute, hour, day or month rolls over and carries on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One-cycle strobe marking a slow timekeeping clock edge |
| sec_tick | input | 1 | Second tick, honoured only together with slow_en |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register selector: 0 control, 1 time, 2 date, 3 none |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected register (combinational) |

## Verification
The bench aims at the instant a write lands. A commit that comes one slow edge early or late, or that lets the coincident tick through, shows up as the time word reading one second off at the first cycle after the commit. The bench also drives the time past midnight at the end of 28-, 29-, 30- and 31-day months, at December 31, and at year offset 63. A wrong month-length table or a lost carry then produces a wrong date word immediately. Out-of-range written fields and writes issued while a flag is busy are included as well, so a design that used equality compares would stall a field, and one that accepted busy writes would commit the second value.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   // field widths
   localparam int SEC_W = 6;
   localparam int MIN_W = 6;
   localparam int HR_W  = 5;
   localparam int DAY_W = 5;
   localparam int MON_W = 4;
   localparam int YR_W  = 6;
   localparam int WORD_W = 32;

   // field positions decoded by software
   localparam int SEC_LSB  = 0;
   localparam int MIN_LSB  = 8;
   localparam int HR_LSB   = 16;
   localparam int DAY_LSB  = 0;
   localparam int MON_LSB  = 8;
   localparam int YR_LSB   = 16;
   localparam int LEAP_POS = 22;

   // busy flags in the control word
   localparam int BUSY_TOD_POS  = 8;
   localparam int BUSY_DATE_POS = 7;

   // last values of the rolling fields
   localparam int SEC_LAST = 59;
   localparam int MIN_LAST = 59;
   localparam int HR_LAST  = 23;
   localparam int MON_LAST = 12;

   typedef struct packed {
      logic [HR_W-1:0]  hr;
      logic [MIN_W-1:0] mn;
      logic [SEC_W-1:0] sc;
   } tod_t;

   typedef struct packed {
      logic             leap;
      logic [YR_W-1:0]  yr;
      logic [MON_W-1:0] mon;
      logic [DAY_W-1:0] day;
   } cal_date_t;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_TOD  = 2'd1,
      SEL_DATE = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   function automatic logic [WORD_W-1:0] tod_to_word(tod_t t);
      logic [WORD_W-1:0] w;
      w = '0;
      w[SEC_LSB +: SEC_W] = t.sc;
      w[MIN_LSB +: MIN_W] = t.mn;
      w[HR_LSB  +: HR_W]  = t.hr;
      return w;
   endfunction

   function automatic tod_t word_to_tod(logic [WORD_W-1:0] w);
      tod_t t;
      t.sc = w[SEC_LSB +: SEC_W];
      t.mn = w[MIN_LSB +: MIN_W];
      t.hr = w[HR_LSB  +: HR_W];
      return t;
   endfunction

   function automatic logic [WORD_W-1:0] date_to_word(cal_date_t d);
      logic [WORD_W-1:0] w;
      w = '0;
      w[DAY_LSB +: DAY_W] = d.day;
      w[MON_LSB +: MON_W] = d.mon;
      w[YR_LSB  +: YR_W]  = d.yr;
      w[LEAP_POS]         = d.leap;
      return w;
   endfunction

   function automatic cal_date_t word_to_date(logic [WORD_W-1:0] w);
      cal_date_t d;
      d.day  = w[DAY_LSB +: DAY_W];
      d.mon  = w[MON_LSB +: MON_W];
      d.yr   = w[YR_LSB  +: YR_W];
      d.leap = w[LEAP_POS];
      return d;
   endfunction

endpackage

// File: rtl/rtc_field_step.sv
// One rolling field: next value and wrap indication.
module rtc_field_step #(
   parameter int W     = 6,
   parameter int FIRST = 0
) (
   input  logic         en,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] last,
   output logic [W-1:0] nxt,
   output logic         wrap
);
   localparam logic [W-1:0] FIRST_V = W'(FIRST);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("rtc_field_step: W out of range");
   end

   assign wrap = (cur >= last);

   always_comb begin
      if (!en)       nxt = cur;
      else if (wrap) nxt = FIRST_V;
      else           nxt = cur + 1'b1;
   end
endmodule

// File: rtl/rtc_commit_sync.sv
// Busy flag plus slow-domain synchronizer for one register's write.
module rtc_commit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_en,
   input  logic req,
   output logic pending,
   output logic commit
);
   if (STAGES < 1 || STAGES > 8) begin : g_bad_stages
      $error("rtc_commit_sync: STAGES must be 1..8");
   end

   logic [STAGES-1:0] stg;
   logic [STAGES-1:0] stg_shift;

   if (STAGES == 1) begin : g_one
      assign stg_shift = pending;
   end else begin : g_many
      assign stg_shift = {stg[STAGES-2:0], pending};
   end

   assign commit = slow_en & stg[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n)      pending <= 1'b0;
      else if (commit) pending <= 1'b0;
      else if (req)    pending <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg <= '0;
      end else if (slow_en) begin
         if (commit) stg <= '0;
         else        stg <= stg_shift;
      end
   end
endmodule

// File: rtl/rtc_tod_ctr.sv
// Seconds / minutes / hours counter with day carry.
module rtc_tod_ctr
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  tod_t load_val,
   input  logic step,
   output tod_t q,
   output logic day_carry
);
   localparam logic [SEC_W-1:0] SEC_LAST_V = SEC_W'(SEC_LAST);
   localparam logic [MIN_W-1:0] MIN_LAST_V = MIN_W'(MIN_LAST);
   localparam logic [HR_W-1:0]  HR_LAST_V  = HR_W'(HR_LAST);

   logic s_wrap, m_wrap, h_wrap;
   logic m_en, h_en;
   tod_t nxt;

   assign m_en = step & s_wrap;
   assign h_en = m_en & m_wrap;
   assign day_carry = h_en & h_wrap;

   rtc_field_step #(.W(SEC_W), .FIRST(0)) i_sec (
      .en(step), .cur(q.sc), .last(SEC_LAST_V), .nxt(nxt.sc), .wrap(s_wrap));
   rtc_field_step #(.W(MIN_W), .FIRST(0)) i_min (
      .en(m_en), .cur(q.mn), .last(MIN_LAST_V), .nxt(nxt.mn), .wrap(m_wrap));
   rtc_field_step #(.W(HR_W), .FIRST(0)) i_hr (
      .en(h_en), .cur(q.hr), .last(HR_LAST_V), .nxt(nxt.hr), .wrap(h_wrap));

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= nxt;
   end
endmodule

// File: rtl/rtc_date_ctr.sv
// Day / month / year counter with stored leap flag.
module rtc_date_ctr
   import rtc_cal_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  cal_date_t load_val,
   input  logic      step,
   output cal_date_t q
);
   localparam logic [MON_W-1:0] MON_LAST_V = MON_W'(MON_LAST);
   localparam logic [YR_W-1:0]  YR_LAST_V  = '1;

   function automatic logic [DAY_W-1:0] month_len(logic [MON_W-1:0] m, logic lp);
      case (m)
         MON_W'(2):  return lp ? DAY_W'(29) : DAY_W'(28);
         MON_W'(4),
         MON_W'(6),
         MON_W'(9),
         MON_W'(11): return DAY_W'(30);
         default:    return DAY_W'(31);
      endcase
   endfunction

   logic [DAY_W-1:0] day_last;
   logic d_wrap, mo_wrap, y_wrap;
   logic mo_en, y_en;
   cal_date_t nxt;

   assign day_last = month_len(q.mon, q.leap);
   assign mo_en    = step & d_wrap;
   assign y_en     = mo_en & mo_wrap;
   assign nxt.leap = q.leap;

   rtc_field_step #(.W(DAY_W), .FIRST(1)) i_day (
      .en(step), .cur(q.day), .last(day_last), .nxt(nxt.day), .wrap(d_wrap));
   rtc_field_step #(.W(MON_W), .FIRST(1)) i_mon (
      .en(mo_en), .cur(q.mon), .last(MON_LAST_V), .nxt(nxt.mon), .wrap(mo_wrap));
   rtc_field_step #(.W(YR_W), .FIRST(0)) i_yr (
      .en(y_en), .cur(q.yr), .last(YR_LAST_V), .nxt(nxt.yr), .wrap(y_wrap));

   logic unused_ywrap;
   assign unused_ywrap = y_wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q      <= '0;
         q.day  <= DAY_W'(1);
         q.mon  <= MON_W'(1);
      end else if (load) begin
         q <= load_val;
      end else if (step) begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
   import rtc_cal_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slow_en,
   input  logic        sec_tick,
   input  logic        wr_en,
   input  logic [1:0]  addr,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data
);
   localparam int NREG = 2;   // index 0: time word, 1: date word

   if (SYNC_STAGES < 1 || SYNC_STAGES > 8) begin : g_bad_sync
      $error("rtc_cal_core: SYNC_STAGES must be 1..8");
   end

   reg_sel_e  sel;
   logic [NREG-1:0] wr_hit;
   logic [NREG-1:0] pend;
   logic [NREG-1:0] commit;
   logic      tick_go;
   logic      tod_carry;
   tod_t      sh_tod, tod_q;
   cal_date_t sh_date, date_q;

   assign sel = reg_sel_e'(addr);

   assign wr_hit[0] = wr_en && (sel == SEL_TOD)  && !pend[0];
   assign wr_hit[1] = wr_en && (sel == SEL_DATE) && !pend[1];

   for (genvar g = 0; g < NREG; g++) begin : g_sync
      rtc_commit_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .slow_en (slow_en),
         .req     (wr_hit[g]),
         .pending (pend[g]),
         .commit  (commit[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_tod  <= '0;
         sh_date <= '0;
      end else begin
         if (wr_hit[0]) sh_tod  <= word_to_tod(wr_data);
         if (wr_hit[1]) sh_date <= word_to_date(wr_data);
      end
   end

   assign tick_go = slow_en & sec_tick & ~(|commit);

   rtc_tod_ctr i_tod (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (commit[0]),
      .load_val  (sh_tod),
      .step      (tick_go),
      .q         (tod_q),
      .day_carry (tod_carry)
   );

   rtc_date_ctr i_date (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (commit[1]),
      .load_val (sh_date),
      .step     (tod_carry),
      .q        (date_q)
   );

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_CTRL: begin
            rd_data[BUSY_TOD_POS]  = pend[0];
            rd_data[BUSY_DATE_POS] = pend[1];
         end
         SEL_TOD:  rd_data = tod_to_word(tod_q);
         SEL_DATE: rd_data = date_to_word(date_q);
         default:  rd_data = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{wr_data[31:23], wr_data[15:14], wr_data[7:6]};
endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk
   import rtc_cal_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       slow_en,
   input logic       sec_tick,
   input logic [1:0] wr_hit,
   input logic [1:0] pend,
   input logic [1:0] commit,
   input tod_t       tod_q,
   input tod_t       sh_tod
);
   logic any_commit;
   assign any_commit = |commit;

   a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[0] |=> pend[0]);

   a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[0] && !commit[0]) |=> pend[0]);

   a_r4_commit_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      commit[0] |-> pend[0]);

   a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      commit[1] |=> !pend[1]);

   a_r4_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
      commit[0] |=> (tod_q == $past(sh_tod)));

   a_r5_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[0] && !commit[0]) |=> $stable(sh_tod));

   a_r10_date_commit_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (commit[1] && !commit[0]) |=> $stable(tod_q));

   a_r7_sec_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_en && sec_tick && !any_commit && (tod_q.sc < SEC_W'(SEC_LAST)))
      |=> (tod_q.sc == SEC_W'($past(tod_q.sc) + SEC_W'(1))));
endmodule

bind rtc_cal_core rtc_cal_core_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .slow_en  (slow_en),
   .sec_tick (sec_tick),
   .wr_hit   (wr_hit),
   .pend     (pend),
   .commit   (commit),
   .tod_q    (tod_q),
   .sh_tod   (sh_tod)
);

// File: tb/test_rtc_cal_core.sv
`timescale 1ns/1ps
module test_rtc_cal_core;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_en = 1'b0;
   logic        sec_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;

   always #2 clk = ~clk;   // 250 MHz

   rtc_cal_core #(.SYNC_STAGES(SYNC)) i_rtc_cal_core (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .sec_tick(sec_tick),
      .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   string cur_req = "R1";

   // reference model state
   int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_leap;
   int s_sec, s_min, s_hr, s_day, s_mon, s_yr, s_leap;
   bit p_t, p_d;
   int e_t, e_d;

   function automatic int mlen(int m, int lp);
      if (m == 2) return lp ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [31:0] expect_rd(logic [1:0] a);
      logic [31:0] w;
      w = '0;
      case (a)
         2'd0: w = (32'(p_t) << 8) | (32'(p_d) << 7);
         2'd1: w = 32'(m_sec) | (32'(m_min) << 8) | (32'(m_hr) << 16);
         2'd2: w = 32'(m_day) | (32'(m_mon) << 8) | (32'(m_yr) << 16) | (32'(m_leap) << 22);
         default: w = '0;
      endcase
      return w;
   endfunction

   task automatic model_reset();
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_leap = 0;
      s_sec = 0; s_min = 0; s_hr = 0; s_day = 0; s_mon = 0; s_yr = 0; s_leap = 0;
      p_t = 0; p_d = 0; e_t = 0; e_d = 0;
   endtask

   task automatic model_advance();
      if (m_sec >= 59) begin
         m_sec = 0;
         if (m_min >= 59) begin
            m_min = 0;
            if (m_hr >= 23) begin
               m_hr = 0;
               if (m_day >= mlen(m_mon, m_leap)) begin
                  m_day = 1;
                  if (m_mon >= 12) begin
                     m_mon = 1;
                     m_yr = (m_yr + 1) % 64;
                  end else m_mon++;
               end else m_day++;
            end else m_hr++;
         end else m_min++;
      end else m_sec++;
   endtask

   task automatic model_step(bit se, bit st, bit we, logic [1:0] a, logic [31:0] d);
      bit c_t, c_d, acc_t, acc_d;
      c_t = se && p_t && (e_t == SYNC);
      c_d = se && p_d && (e_d == SYNC);
      acc_t = we && (a == 2'd1) && !p_t;
      acc_d = we && (a == 2'd2) && !p_d;
      if (se && p_t && !c_t) e_t++;
      if (se && p_d && !c_d) e_d++;
      if (se && st && !c_t && !c_d) model_advance();
      if (c_t) begin m_sec = s_sec; m_min = s_min; m_hr = s_hr; p_t = 0; end
      if (c_d) begin
         m_day = s_day; m_mon = s_mon; m_yr = s_yr; m_leap = s_leap; p_d = 0;
      end
      if (acc_t) begin
         s_sec = int'(d[5:0]); s_min = int'(d[13:8]); s_hr = int'(d[20:16]);
         p_t = 1; e_t = 0;
      end
      if (acc_d) begin
         s_day = int'(d[4:0]); s_mon = int'(d[11:8]); s_yr = int'(d[21:16]);
         s_leap = int'(d[22]); p_d = 1; e_d = 0;
      end
   endtask

   // one clock: drive, compare the addressed register, advance the model
   task automatic cyc(bit se, bit st, bit we, logic [1:0] a, logic [31:0] d);
      logic [31:0] exp_v;
      @(negedge clk);
      slow_en = se; sec_tick = st; wr_en = we; addr = a; wr_data = d;
      #1;
      exp_v = expect_rd(a);
      vectors++;
      if (rd_data !== exp_v) begin
         miscompares++;
         $display("FAIL %s addr %0d got %h expected %h", cur_req, a, rd_data, exp_v);
      end
      @(posedge clk);
      model_step(se, st, we, a, d);
   endtask

   // idle cycles reading all selectors in turn, slow edge every other cycle
   task automatic idle(int n, bit tick);
      for (int i = 0; i < n; i++) cyc((i % 2) == 1, tick, 1'b0, 2'(i % 4), 32'h0);
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      cyc(1'b0, 1'b0, 1'b1, a, d);
   endtask

   function automatic logic [31:0] tw(int h, int m, int s);
      return 32'(s) | (32'(m) << 8) | (32'(h) << 16);
   endfunction

   function automatic logic [31:0] dw(int lp, int y, int mo, int dd);
      return 32'(dd) | (32'(mo) << 8) | (32'(y) << 16) | (32'(lp) << 22);
   endfunction

   task automatic set_all(logic [31:0] t, logic [31:0] d);
      wr(2'd1, t);
      wr(2'd2, d);
      idle(12, 1'b0);
   endtask

   task automatic run_to_midnight(logic [31:0] d);
      set_all(tw(23, 59, 57), d);
      idle(16, 1'b1);
   endtask

   initial begin
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      cur_req = "R1";  idle(8, 1'b0);

      cur_req = "R3";  wr(2'd1, tw(12, 34, 56));
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
      cur_req = "R6";  for (int i = 0; i < 4; i++) cyc(i % 2 == 1, 1'b1, 1'b0, 2'd1, 32'h0);
      cur_req = "R4";  for (int i = 0; i < 6; i++) cyc(i % 2 == 1, 1'b1, 1'b0, 2'(i % 2), 32'h0);
      cur_req = "R3";  wr(2'd2, dw(1, 50, 2, 14));
      for (int i = 0; i < 8; i++) cyc(i % 2 == 1, 1'b0, 1'b0, 2'(i % 3), 32'h0);

      cur_req = "R5";  wr(2'd1, tw(1, 2, 3));
      wr(2'd1, tw(9, 9, 9));
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      idle(12, 1'b0);

      cur_req = "R2";  set_all(32'hFFC0_C0C0 | tw(7, 8, 9), 32'hFF80_F0E0 | dw(0, 3, 7, 4));
      idle(8, 1'b1);

      cur_req = "R7";  set_all(tw(10, 58, 55), dw(0, 30, 6, 10));
      idle(24, 1'b1);
      run_to_midnight(dw(0, 30, 6, 10));

      cur_req = "R8";  run_to_midnight(dw(0, 31, 2, 28));
      run_to_midnight(dw(1, 30, 2, 28));
      run_to_midnight(dw(1, 30, 2, 29));
      run_to_midnight(dw(0, 30, 4, 30));
      run_to_midnight(dw(0, 30, 1, 31));
      run_to_midnight(dw(0, 30, 11, 30));

      cur_req = "R9";  run_to_midnight(dw(1, 5, 12, 31));
      run_to_midnight(dw(0, 63, 12, 31));

      cur_req = "R10"; wr(2'd1, tw(4, 5, 6));
      for (int i = 0; i < 12; i++) cyc(i % 2 == 1, 1'b1, 1'b0, 2'd1, 32'h0);
      wr(2'd2, dw(0, 9, 3, 3));
      for (int i = 0; i < 12; i++) cyc(i % 2 == 1, 1'b1, 1'b0, 2'(1 + (i % 2)), 32'h0);

      cur_req = "R11"; set_all(32'hFFFF_FFFF, dw(0, 1, 15, 31));
      idle(12, 1'b1);
      set_all(tw(23, 61, 62), dw(0, 1, 6, 31));
      idle(12, 1'b1);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, got hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule